// File: doc/BRIEF.md
# Password-protected watchdog timer

This block is a watchdog counter that sits behind a small 32-bit register bus. Once armed by software, it decrements a 16-bit count at a selectable prescaled rate. If software fails to refresh the count before it runs out, the block raises a one-cycle reset request and stops itself. An early-warning output goes high once the remaining count falls to a selectable fraction of the full 16-bit range. This gives software a last chance to act before the reset.

Every change to the control word is guarded by a two-write unlock. The first write must carry one magic byte in the key field, and nothing else happens on that write. The next bus access must be a control write that carries the second magic byte. The configuration and reload value are taken from that second write. The same unlocked write serves as start, stop and keepalive: it always reloads the count from its reload field. A read-only status word reports the running state and the live count.

Top module: `pwd_watchdog`

## Requirements
- R1: After reset the timer is stopped. The control word reads 0x0000FFFF and the status word reads 0x0000FFFF. Both the reset request and the warning output are low.
- R2: A control write (offset 0x0) with key bits 23:16 equal to 0xBE arms the unlock. If the next bus access is a control write with key 0xDC, that write takes effect. It sets run (bit 31), warning select (bits 27:26), divider select (bits 25:24) and reload (bits 15:0).
- R3: If the arming write's key is not 0xBE, or the following control write's key is not 0xDC, the write has no effect and the unlock returns to idle. A later 0xDC write alone then changes nothing.
- R4: Any other bus access between the arming write and the 0xDC write cancels the unlock. This covers a read of either offset and a write to another offset.
- R5: A control read returns run at bit 31, warning select at 27:26, divider select at 25:24 and reload at 15:0. Bits 30:28 and the key bits 23:16 always read zero.
- R6: A status read (offset 0x8) returns the run state at bit 31 and the live count at bits 15:0. All other bits read zero.
- R7: While running, the count drops by one every 1, 64, 4096 or 262144 clock cycles for divider select 0, 1, 2 and 3. The first decrement comes that many cycles after the unlocked write.
- R8: When a decrement takes the count to zero, the count stays at zero and the run bit clears. The reset request is high for exactly the one following cycle. With divider 0 and reload N, this happens on the N-th clock edge after the unlocked write.
- R9: While running, the warning output rises one cycle after the count first equals or falls below 32768, 16384, 8192 or 4096, for warning select 0 to 3. It stays high, even after expiry, until the next unlocked write.
- R10: An unlocked write reloads the count from its reload field, restarts the prescaler and clears the warning. This lets a keepalive postpone expiry.
- R11: An unlocked write with bit 31 clear stops the timer. The count then holds and no reset request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| rst_req | output | 1 | One-cycle reset request on expiry |
| prewarn | output | 1 | Sticky early-warning flag |

## Verification
A wrong unlock state shows up on the very next control read. A write that should have been refused would change the control readback, and a good sequence that is lost would leave the old configuration in place. A count or prescaler that is off by even one cycle moves the reset-request pulse. The bench therefore samples that pulse on the exact edge and on the edge before it, and reads the status count inside long divider windows. A warning threshold decoded wrongly moves the warning edge relative to the count, so each setting is probed on the cycle before and the cycle of the expected rise.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 4;
    localparam int CNT_W    = 16;
    localparam int PRE_W    = 18;
    localparam int SEL_W    = 2;
    localparam int KEY_LSB  = 16;
    localparam int KEY_W    = 8;

    localparam logic [KEY_W-1:0]  KEY_ARM    = 8'hBE;
    localparam logic [KEY_W-1:0]  KEY_COMMIT = 8'hDC;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 4'h8;

    typedef struct packed {
        logic             run;
        logic [SEL_W-1:0] warn_sel;
        logic [SEL_W-1:0] div_sel;
        logic [CNT_W-1:0] reload;
    } wdg_cfg_t;

    localparam wdg_cfg_t CFG_RESET = '{run: 1'b0, warn_sel: '0, div_sel: '0,
                                       reload: {CNT_W{1'b1}}};

    // log2 of the prescaler ratio for each divider select
    function automatic logic [4:0] div_shift(input logic [SEL_W-1:0] sel);
        case (sel)
            2'd0:    return 5'd0;
            2'd1:    return 5'd6;
            2'd2:    return 5'd12;
            default: return 5'd18;
        endcase
    endfunction

    // warning threshold: full range divided by 2, 4, 8 or 16
    function automatic logic [CNT_W:0] warn_level(input logic [SEL_W-1:0] sel);
        logic [CNT_W:0] full;
        full = {1'b1, {CNT_W{1'b0}}};
        return full >> (sel + 1);
    endfunction

    // control readback: key field and spare bits read as zero
    function automatic logic [BUS_W-1:0] ctrl_word(input wdg_cfg_t c);
        return {c.run, 3'b000, c.warn_sel, c.div_sel, {KEY_W{1'b0}}, c.reload};
    endfunction

endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BUS_W-1:0]  acc_wdata,
    input  logic              expire,
    output logic              apply,
    output wdg_cfg_t          cfg
);
    logic             armed;
    logic             ctrl_wr;
    logic [KEY_W-1:0] key;

    assign key     = acc_wdata[KEY_LSB +: KEY_W];
    assign ctrl_wr = acc_valid && acc_write && (acc_addr == OFS_CTRL);
    assign apply   = ctrl_wr && armed && (key == KEY_COMMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cfg   <= CFG_RESET;
        end else begin
            if (ctrl_wr)
                armed <= !armed && (key == KEY_ARM);
            else if (acc_valid)
                armed <= 1'b0;

            if (apply) begin
                cfg.run      <= acc_wdata[BUS_W-1];
                cfg.warn_sel <= acc_wdata[27:26];
                cfg.div_sel  <= acc_wdata[25:24];
                cfg.reload   <= acc_wdata[CNT_W-1:0];
            end else if (expire) begin
                cfg.run <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W:0]   last;

    assign last = ({{PRE_W{1'b0}}, 1'b1} << div_shift(sel)) - 1'b1;
    assign tick = run && ({1'b0, pcnt} == last);

    always_ff @(posedge clk) begin
        if (rst || restart || !run || tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             apply,
    input  logic [CNT_W-1:0] load_val,
    input  logic [SEL_W-1:0] warn_sel,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             rst_req,
    output logic             prewarn
);
    logic near_end;

    assign expire   = run && tick && !apply && (count <= CNT_W'(1));
    assign near_end = ({1'b0, count} <= warn_level(warn_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= {CNT_W{1'b1}};
            rst_req <= 1'b0;
            prewarn <= 1'b0;
        end else begin
            rst_req <= expire;
            if (apply) begin
                count   <= load_val;
                prewarn <= 1'b0;
            end else begin
                if (run && tick && count != '0)
                    count <= count - 1'b1;
                if (run && near_end)
                    prewarn <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              rst_req,
    output logic              prewarn
);
    wdg_cfg_t         cfg;
    logic             apply;
    logic             expire;
    logic             tick;
    logic             run_now;
    logic [CNT_W-1:0] count;

    assign run_now = cfg.run;

    wdg_unlock u_unlock (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (bus_sel),
        .acc_write (bus_we),
        .acc_addr  (bus_addr),
        .acc_wdata (bus_wdata),
        .expire    (expire),
        .apply     (apply),
        .cfg       (cfg)
    );

    wdg_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg.run),
        .restart (apply),
        .sel     (cfg.div_sel),
        .tick    (tick)
    );

    wdg_countdown u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (cfg.run),
        .apply    (apply),
        .load_val (bus_wdata[CNT_W-1:0]),
        .warn_sel (cfg.warn_sel),
        .tick     (tick),
        .count    (count),
        .expire   (expire),
        .rst_req  (rst_req),
        .prewarn  (prewarn)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                OFS_CTRL: bus_rdata = ctrl_word(cfg);
                OFS_STAT: bus_rdata = {cfg.run, {(BUS_W-CNT_W-1){1'b0}}, count};
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
    import wdg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              rst_req,
    input logic              prewarn,
    input logic              run,
    input logic              apply,
    input logic [CNT_W-1:0]  count
);
    logic other_acc;
    assign other_acc = bus_sel && !(bus_we && bus_addr == OFS_CTRL);

    AST_RSTREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req); // R8
    AST_EXPIRY_STOPS: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !run); // R8
    AST_CANCEL_BY_OTHER: assert property (@(posedge clk) disable iff (rst)
        other_acc |=> !apply); // R4
    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !apply) |=> $stable(count)); // R11
    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
        (run && !apply) |=> (count == $past(count) || count == $past(count) - 1'b1)); // R7
    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (prewarn && !apply) |=> prewarn); // R9
    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == OFS_CTRL) |-> bus_rdata[23:16] == 8'h00); // R5
    AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == OFS_STAT) |-> bus_rdata[30:16] == 15'h0); // R6
endmodule

bind pwd_watchdog wdg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req),
    .prewarn   (prewarn),
    .run       (run_now),
    .apply     (apply),
    .count     (count)
);

// File: tb/pwd_watchdog_bench.sv
`timescale 1ns/1ps
module pwd_watchdog_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;
    logic        prewarn;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwd_watchdog u_pwd_watchdog (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .prewarn(prewarn)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] cfgw(input logic en, input logic [1:0] wsel,
                                         input logic [1:0] dsel, input logic [15:0] rl);
        return {en, 3'b000, wsel, dsel, 8'hDC, rl};
    endfunction

    function automatic logic [31:0] rdback(input logic en, input logic [1:0] wsel,
                                           input logic [1:0] dsel, input logic [15:0] rl);
        return {en, 3'b000, wsel, dsel, 8'h00, rl};
    endfunction

    // two-edge unlock; returns at the negedge just after the commit edge
    task automatic unlock(input logic [31:0] w);
        wr(4'h0, 32'h00BE_0000);
        wr(4'h0, w);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1", "rst_req", {31'b0, rst_req}, 32'h0);
        check("R1", "prewarn", {31'b0, prewarn}, 32'h0);
        rd(4'h0, d); check("R1", "ctrl", d, 32'h0000_FFFF);
        rd(4'h8, d); check("R1", "status", d, 32'h0000_FFFF);
    endtask

    task automatic t_commit;
        logic [31:0] d;
        unlock(cfgw(1'b1, 2'd2, 2'd1, 16'h1234));
        rd(4'h0, d); check("R2", "ctrl after commit", d, 32'h8900_1234);
        check("R5", "key field zero", {24'h0, d[23:16]}, 32'h0);
        rd(4'h8, d); check("R6", "status running", d, 32'h8000_1234);
        check("R9", "warn below 8192", {31'b0, prewarn}, 32'h1);
        unlock(cfgw(1'b0, 2'd0, 2'd0, 16'hFFFF));
        check("R10", "warn cleared by write", {31'b0, prewarn}, 32'h0);
        rd(4'h8, d); check("R11", "status stopped", d, 32'h0000_FFFF);
    endtask

    task automatic t_bad_key;
        logic [31:0] d;
        wr(4'h0, 32'h00BF_0000);
        wr(4'h0, cfgw(1'b1, 2'd0, 2'd0, 16'd5));
        rd(4'h0, d); check("R3", "wrong arm key", d, 32'h0000_FFFF);
        wr(4'h0, 32'h00BE_0000);
        wr(4'h0, {1'b1, 7'h0, 8'hDD, 16'd5});
        wr(4'h0, cfgw(1'b1, 2'd0, 2'd0, 16'd5));
        rd(4'h0, d); check("R3", "wrong commit key then lone commit", d, 32'h0000_FFFF);
    endtask

    task automatic t_cancel;
        logic [31:0] d;
        wr(4'h0, 32'h00BE_0000);
        rd(4'h8, d);
        wr(4'h0, cfgw(1'b1, 2'd0, 2'd0, 16'd5));
        rd(4'h0, d); check("R4", "status read cancels", d, 32'h0000_FFFF);
        wr(4'h0, 32'h00BE_0000);
        wr(4'h4, 32'h00DC_0000);
        wr(4'h0, cfgw(1'b1, 2'd0, 2'd0, 16'd5));
        rd(4'h0, d); check("R4", "other write cancels", d, 32'h0000_FFFF);
        wr(4'h0, 32'h00BE_0000);
        rd(4'h0, d);
        wr(4'h0, cfgw(1'b1, 2'd0, 2'd0, 16'd5));
        rd(4'h0, d); check("R4", "ctrl read cancels", d, 32'h0000_FFFF);
    endtask

    task automatic t_expire;
        logic [31:0] d;
        unlock(cfgw(1'b1, 2'd0, 2'd0, 16'd10));
        idle(9);  check("R8", "no request before zero", {31'b0, rst_req}, 32'h0);
        idle(1);  check("R8", "request at zero", {31'b0, rst_req}, 32'h1);
        idle(1);  check("R8", "request one cycle", {31'b0, rst_req}, 32'h0);
        check("R9", "warn stays after expiry", {31'b0, prewarn}, 32'h1);
        rd(4'h8, d); check("R8", "status after expiry", d, 32'h0000_0000);
        rd(4'h0, d); check("R5", "ctrl after expiry", d, rdback(1'b0, 2'd0, 2'd0, 16'd10));
    endtask

    task automatic t_divider;
        logic [31:0] d;
        unlock(cfgw(1'b1, 2'd0, 2'd1, 16'd5));
        idle(319); check("R7", "div64 early", {31'b0, rst_req}, 32'h0);
        idle(1);   check("R7", "div64 expiry", {31'b0, rst_req}, 32'h1);
        unlock(cfgw(1'b1, 2'd0, 2'd2, 16'd2));
        idle(8191); check("R7", "div4096 early", {31'b0, rst_req}, 32'h0);
        idle(1);    check("R7", "div4096 expiry", {31'b0, rst_req}, 32'h1);
        unlock(cfgw(1'b1, 2'd0, 2'd3, 16'd3));
        idle(5000);
        rd(4'h8, d); check("R7", "div262144 no step yet", d, 32'h8000_0003);
        unlock(cfgw(1'b0, 2'd0, 2'd0, 16'hFFFF));
    endtask

    task automatic t_prewarn;
        for (int s = 0; s < 4; s++) begin
            logic [15:0] thr;
            thr = 16'(32'd32768 >> s);
            unlock(cfgw(1'b1, 2'(s), 2'd0, thr + 16'd6));
            idle(6); check("R9", $sformatf("warn sel %0d before", s), {31'b0, prewarn}, 32'h0);
            idle(1); check("R9", $sformatf("warn sel %0d rise", s), {31'b0, prewarn}, 32'h1);
            unlock(cfgw(1'b0, 2'd0, 2'd0, 16'hFFFF));
        end
    endtask

    task automatic t_keepalive;
        unlock(cfgw(1'b1, 2'd3, 2'd0, 16'd4200));
        idle(120);
        check("R9", "warn set before keepalive", {31'b0, prewarn}, 32'h1);
        unlock(cfgw(1'b1, 2'd3, 2'd0, 16'd4200));
        check("R10", "keepalive clears warn", {31'b0, prewarn}, 32'h0);
        unlock(cfgw(1'b1, 2'd0, 2'd0, 16'd10));
        idle(6);
        unlock(cfgw(1'b1, 2'd0, 2'd0, 16'd10));
        idle(9); check("R10", "expiry postponed", {31'b0, rst_req}, 32'h0);
        idle(1); check("R10", "expiry after reload", {31'b0, rst_req}, 32'h1);
    endtask

    task automatic t_stop;
        logic [31:0] d;
        logic seen;
        seen = 1'b0;
        unlock(cfgw(1'b1, 2'd0, 2'd0, 16'd50));
        idle(5);
        unlock(cfgw(1'b0, 2'd0, 2'd0, 16'd50));
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (rst_req) seen = 1'b1;
        end
        check("R11", "no request after stop", {31'b0, seen}, 32'h0);
        rd(4'h8, d); check("R11", "count held", d, 32'h0000_0032);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        t_commit();
        t_bad_key();
        t_cancel();
        t_expire();
        t_divider();
        t_prewarn();
        t_keepalive();
        t_stop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule